// File: doc/BRIEF.md
# Two-Wire Serial Programming Target

This block is the device-side end of a two-wire in-system programming link. An external programmer toggles a clock pin and drives or samples a shared data pin. The block oversamples both pins with its own system clock, assembles 6-bit commands, moves 16-clock data frames in either direction and turns the data pin around for reads. Recognised commands become single-cycle strobes towards a memory that lives outside the block.

A program counter selects the word being worked on. It has a user half, in which only the low part of the address space is physical and the rest aliases onto it, and a configuration half that, once entered, cannot be left except by reset. The synchronous reset stands for leaving programming mode: it clears the counter and returns the receiver to command collection.

Top module: `tgt_prog_if`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pc_o` is 0, `sdat_oe` is 0 and no strobe (`wr_stb`, `dwr_stb`, `op_stb`) is raised.
- R2: A command is 6 pin clocks; the bit on `sdat_i` is taken at each falling edge of `sclk_i`, least significant bit first. Only the low five bits select the command; bit 5 has no effect.
- R3: Low five bits 01000, 11000, 01001, 01011, 11111, 10111 raise `op_stb` for one cycle with `op_code` 0 (row erase), 1 (program), 2 (bulk erase program), 3 (bulk erase data), 4 (chip erase), 5 (end). Unlisted codes raise no strobe and leave the counter unchanged; at most one strobe is high in any cycle.
- R4: Code 00010 is followed by a 16-clock frame: a start bit, 14 data bits LSb first taken at falls 2 to 15, a stop bit. After the 16th fall `wr_stb` pulses once with the word on `wr_data`.
- R5: Code 00011 takes the same 16-clock frame but `dwr_stb` carries only the 8 bits after the start bit on `dwr_data`; the other 6 are discarded.
- R6: Code 00100 sends the word on `prog_rdata` for the current address: `sdat_oe` rises at the frame's 2nd rising edge, bit k is on `sdat_o` from rising edge k+2, and `sdat_oe` drops at the 16th rising edge. The output enable changes only at rising edges.
- R7: Code 00101 sends `dmem_rdata` in the low 8 bits followed by 6 zeros; with `cp_data_i` high all 14 bits are zero.
- R8: Code 00000 sets the counter to the configuration base (only the top bit set) and its 16-clock frame produces no strobe.
- R9: Code 00110 increments the counter; from the last user address (top bit clear, all others set) it steps to the configuration base.
- R10: In the configuration half the top counter bit stays set until reset; the last address wraps to the base.
- R11: In the user half `mem_addr` equals the counter with all bits at and above `PHYS_W` cleared; in the configuration half it equals the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst | input | 1 | Synchronous reset, leaves programming mode |
| sclk_i | input | 1 | Serial clock pin level |
| sdat_i | input | 1 | Serial data pin, input side |
| sdat_o | output | 1 | Serial data pin, output side |
| sdat_oe | output | 1 | Data pin drive enable |
| cp_data_i | input | 1 | Data memory protection flag |
| prog_rdata | input | DW | Program word at `mem_addr` |
| dmem_rdata | input | DMW | Data byte at `mem_addr` |
| mem_addr | output | PC_W | Physical address after aliasing |
| pc_o | output | PC_W | Program counter |
| wr_stb | output | 1 | Program word load strobe |
| wr_data | output | DW | Program word to load |
| dwr_stb | output | 1 | Data byte load strobe |
| dwr_data | output | DMW | Data byte to load |
| op_stb | output | 1 | Operation strobe |
| op_code | output | 3 | Operation selector |

## Verification
The hardest states to reach are the two counter boundaries: the step out of the last user address and the wrap inside the configuration half each need a full half-space of increment commands. The bench builds the block with a 10-bit counter and 8 physical bits, so each half takes 512 serial commands, and checks the alias point, the crossing and the wrap on the way. Read frames are checked bit by bit at every rising edge, including the enable around the turnaround.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  typedef enum logic {ST_CMD, ST_FRAME} st_e;

  typedef enum logic [2:0] {
    OP_ERASE = 3'd0,
    OP_PROG  = 3'd1,
    OP_BULKP = 3'd2,
    OP_BULKD = 3'd3,
    OP_CHIP  = 3'd4,
    OP_END   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    FK_NONE, FK_CFG, FK_LDP, FK_LDD, FK_RDP, FK_RDD
  } frame_e;

  typedef struct packed {
    frame_e frame;
    logic   op_vld;
    op_e    op;
    logic   inc;
  } dec_t;

  function automatic dec_t decode_cmd(input logic [4:0] c);
    dec_t d;
    d = '{frame: FK_NONE, op_vld: 1'b0, op: OP_ERASE, inc: 1'b0};
    case (c)
      5'b00000: d.frame = FK_CFG;
      5'b00010: d.frame = FK_LDP;
      5'b00011: d.frame = FK_LDD;
      5'b00100: d.frame = FK_RDP;
      5'b00101: d.frame = FK_RDD;
      5'b00110: d.inc = 1'b1;
      5'b01000: begin d.op_vld = 1'b1; d.op = OP_ERASE; end
      5'b11000: begin d.op_vld = 1'b1; d.op = OP_PROG;  end
      5'b01001: begin d.op_vld = 1'b1; d.op = OP_BULKP; end
      5'b01011: begin d.op_vld = 1'b1; d.op = OP_BULKD; end
      5'b11111: begin d.op_vld = 1'b1; d.op = OP_CHIP;  end
      5'b10111: begin d.op_vld = 1'b1; d.op = OP_END;   end
      default:  ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tpi_edge.sv
module tpi_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/tpi_pc.sv
module tpi_pc #(
  parameter int PC_W   = 14,
  parameter int PHYS_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc_i,
  input  logic            cfg_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] addr_o
);
  localparam logic [PC_W-1:0] CFG_BASE  = PC_W'(1) << (PC_W-1);
  localparam logic [PC_W-1:0] USER_MASK = (PC_W'(1) << PHYS_W) - PC_W'(1);

  function automatic logic [PC_W-1:0] next_pc(input logic [PC_W-1:0] p);
    if (p[PC_W-1]) return {1'b1, p[PC_W-2:0] + 1'b1};
    else           return p + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] phys_addr(input logic [PC_W-1:0] p);
    if (p[PC_W-1]) return p;
    else           return p & USER_MASK;
  endfunction

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (cfg_i) pc_q <= CFG_BASE;
    else if (inc_i) pc_q <= next_pc(pc_q);
  end

  assign pc_o   = pc_q;
  assign addr_o = phys_addr(pc_q);
endmodule

// File: rtl/tgt_prog_if.sv
module tgt_prog_if #(
  parameter int PC_W   = 14,
  parameter int PHYS_W = 12,
  parameter int DW     = 14,
  parameter int DMW    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_i,
  input  logic            sdat_i,
  output logic            sdat_o,
  output logic            sdat_oe,
  input  logic            cp_data_i,
  input  logic [DW-1:0]   prog_rdata,
  input  logic [DMW-1:0]  dmem_rdata,
  output logic [PC_W-1:0] mem_addr,
  output logic [PC_W-1:0] pc_o,
  output logic            wr_stb,
  output logic [DW-1:0]   wr_data,
  output logic            dwr_stb,
  output logic [DMW-1:0]  dwr_data,
  output logic            op_stb,
  output logic [2:0]      op_code
);
  import tpi_pkg::*;

  localparam int CMD_LEN   = 6;
  localparam int FRAME_LEN = DW + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

  st_e             st;
  frame_e          kind;
  logic [CNT_W-1:0] cnt;
  logic [4:0]      shreg;
  logic [DW-1:0]   tx, rx;
  logic            rise_w, fall_w;
  logic            cmd_done_w, pc_inc_w, pc_cfg_w, in_frame_w, rd_kind_w;
  dec_t            dec_w;
  logic [DW-1:0]   rd_word_w;

  tpi_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(sclk_i), .rise_o(rise_w), .fall_o(fall_w)
  );

  assign dec_w      = decode_cmd(shreg);
  assign cmd_done_w = (st == ST_CMD) && fall_w && (cnt == CMD_LAST);
  assign pc_inc_w   = cmd_done_w && dec_w.inc;
  assign pc_cfg_w   = cmd_done_w && (dec_w.frame == FK_CFG);
  assign in_frame_w = (st == ST_FRAME);
  assign rd_kind_w  = (kind == FK_RDP) || (kind == FK_RDD);
  assign rd_word_w  = (dec_w.frame == FK_RDP) ? prog_rdata :
                      cp_data_i ? '0 : {{(DW-DMW){1'b0}}, dmem_rdata};

  tpi_pc #(.PC_W(PC_W), .PHYS_W(PHYS_W)) u_pc (
    .clk(clk), .rst(rst), .inc_i(pc_inc_w), .cfg_i(pc_cfg_w),
    .pc_o(pc_o), .addr_o(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CMD;
      kind     <= FK_NONE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      rx       <= '0;
      sdat_o   <= 1'b0;
      sdat_oe  <= 1'b0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      dwr_stb  <= 1'b0;
      dwr_data <= '0;
      op_stb   <= 1'b0;
      op_code  <= '0;
    end else begin
      wr_stb  <= 1'b0;
      dwr_stb <= 1'b0;
      op_stb  <= 1'b0;
      case (st)
        ST_CMD: begin
          if (fall_w) begin
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              if (dec_w.op_vld) begin
                op_stb  <= 1'b1;
                op_code <= dec_w.op;
              end
              if (dec_w.frame != FK_NONE) begin
                st   <= ST_FRAME;
                kind <= dec_w.frame;
                tx   <= rd_word_w;
              end
            end else begin
              shreg <= {sdat_i, shreg[4:1]};
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (rise_w && rd_kind_w) begin
            if (cnt == FRAME_LAST) begin
              sdat_oe <= 1'b0;
              sdat_o  <= 1'b0;
            end else if (cnt != '0) begin
              sdat_oe <= 1'b1;
              sdat_o  <= tx[0];
              tx      <= tx >> 1;
            end
          end
          if (fall_w) begin
            if (cnt == FRAME_LAST) begin
              cnt <= '0;
              st  <= ST_CMD;
              if (kind == FK_LDP) begin
                wr_stb  <= 1'b1;
                wr_data <= rx;
              end
              if (kind == FK_LDD) begin
                dwr_stb  <= 1'b1;
                dwr_data <= rx[DMW-1:0];
              end
            end else begin
              if (cnt != '0) rx <= {sdat_i, rx[DW-1:1]};
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/tpi_chk.sv
module tpi_chk #(
  parameter int PC_W = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            rise_w,
  input logic            fall_w,
  input logic            in_frame_w,
  input logic            sdat_oe,
  input logic [PC_W-1:0] pc_o,
  input logic            wr_stb,
  input logic            dwr_stb,
  input logic            op_stb
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !sdat_oe && !wr_stb && !dwr_stb && !op_stb));

  // R10
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pc_o[PC_W-1] |=> pc_o[PC_W-1]);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_stb, dwr_stb, op_stb}) <= 1);

  // R4
  load_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || dwr_stb) |-> $past(fall_w));

  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sdat_oe |-> in_frame_w);

  // R6
  oe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sdat_oe)) |-> $past(rise_w));
endmodule

bind tgt_prog_if tpi_chk #(.PC_W(PC_W)) u_tpi_chk (
  .clk(clk), .rst(rst), .rise_w(rise_w), .fall_w(fall_w),
  .in_frame_w(in_frame_w), .sdat_oe(sdat_oe), .pc_o(pc_o),
  .wr_stb(wr_stb), .dwr_stb(dwr_stb), .op_stb(op_stb)
);

// File: tb/test_tgt_prog_if.sv
module test_tgt_prog_if;
  localparam int PC_W = 10, PHYS_W = 8, DW = 14, DMW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b0, sdat = 1'b0, cp = 1'b0;
  logic sdat_o, sdat_oe, wr_stb, dwr_stb, op_stb;
  logic [DW-1:0] prog_rdata, wr_data;
  logic [DMW-1:0] dmem_rdata, dwr_data;
  logic [PC_W-1:0] mem_addr, pc_o;
  logic [2:0] op_code;

  int nchk = 0, nbad = 0, nstrobe = 0;

  function automatic logic [DW-1:0] mw(input logic [PC_W-1:0] a);
    return DW'({4'b0, a}) * 14'd7 + 14'h1A5;
  endfunction
  assign prog_rdata = mw(mem_addr);
  assign dmem_rdata = mem_addr[7:0] ^ 8'hC3;

  tgt_prog_if #(.PC_W(PC_W), .PHYS_W(PHYS_W), .DW(DW), .DMW(DMW)) i_tgt_prog_if (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat), .sdat_o(sdat_o),
    .sdat_oe(sdat_oe), .cp_data_i(cp), .prog_rdata(prog_rdata),
    .dmem_rdata(dmem_rdata), .mem_addr(mem_addr), .pc_o(pc_o),
    .wr_stb(wr_stb), .wr_data(wr_data), .dwr_stb(dwr_stb), .dwr_data(dwr_data),
    .op_stb(op_stb), .op_code(op_code)
  );

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int v, input string req);
    exp_t e;
    e.kind = k; e.val = 16'(v); e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops expectations as strobes appear
  always @(negedge clk) begin
    if (!rst && (wr_stb || dwr_stb || op_stb)) begin
      int k;
      logic [15:0] v;
      exp_t e;
      nstrobe++;
      k = wr_stb ? 0 : dwr_stb ? 1 : 2;
      v = wr_stb ? {2'b0, wr_data} : dwr_stb ? {8'b0, dwr_data} : {13'b0, op_code};
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected strobe", k * 65536 + int'(v), -1);
      end else begin
        e = exp_q.pop_front();
        chk(e.kind == k && e.val == v, e.req, k * 65536 + int'(v), e.kind * 65536 + int'(e.val));
      end
    end
  end

  task automatic pin_bit(input logic b);
    @(negedge clk); sdat = b; sclk = 1'b1;
    @(negedge clk); @(negedge clk); sclk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pin_bit(c[i]);
  endtask

  task automatic frame_in(input logic [DW-1:0] v);
    pin_bit(1'b0);
    for (int i = 0; i < DW; i++) pin_bit(v[i]);
    pin_bit(1'b0);
  endtask

  task automatic frame_rd(input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] got = '0;
    bit oe_bad = 0;
    for (int k = 1; k <= DW + 2; k++) begin
      @(negedge clk); sdat = 1'b0; sclk = 1'b1;
      @(negedge clk);
      if (k >= 2 && k <= DW + 1) begin
        if (sdat_oe !== 1'b1) oe_bad = 1;
        got[k-2] = sdat_o;
      end else if (sdat_oe !== 1'b0) oe_bad = 1;
      @(negedge clk); sclk = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    chk(!oe_bad && got == exp, req, {oe_bad, got}, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_o == 0 && sdat_oe == 0 && mem_addr == 0, "R1 reset state", pc_o, 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 program word load
    push(0, 14'h2A5C, "R4 load program word");
    cmd(6'b000010); frame_in(14'h2A5C);
    // R2 sixth bit ignored on a load
    push(0, 14'h1357, "R2 bit5 set load");
    cmd(6'b100010); frame_in(14'h1357);
    // R5 data memory load keeps low 8 bits
    push(1, 8'h5A, "R5 data load low byte");
    cmd(6'b000011); frame_in(14'h3F5A);

    // R3 operation codes
    push(2, 0, "R3 erase"); cmd(6'b001000);
    push(2, 1, "R3 program"); cmd(6'b011000);
    push(2, 2, "R3 bulk program"); cmd(6'b001001);
    push(2, 3, "R3 bulk data"); cmd(6'b001011);
    push(2, 4, "R3 chip erase"); cmd(6'b011111);
    push(2, 5, "R3 end"); cmd(6'b010111);
    repeat (4) @(negedge clk);
    n0 = nstrobe;
    cmd(6'b001111); cmd(6'b000001);
    repeat (4) @(negedge clk);
    chk(nstrobe == n0 && pc_o == 0, "R3 unknown codes inert", nstrobe - n0, 0);

    // R6 program read at address 0
    cmd(6'b000100); frame_rd(mw(0), "R6 read program word");
    // R7 data memory read
    cmd(6'b000101); frame_rd({6'b0, 8'h00 ^ 8'hC3}, "R7 read data byte");
    cp = 1'b1;
    cmd(6'b000101); frame_rd(14'h0, "R7 protected read zero");
    cp = 1'b0;

    // R2 increment with bit5 set
    cmd(6'b100110);
    chk(pc_o == 1, "R2 bit5 set increment", pc_o, 1);
    cmd(6'b000100); frame_rd(mw(1), "R6 read at address 1");

    // R11 alias point
    for (int i = 1; i < 256; i++) cmd(6'b000110);
    chk(pc_o == 10'h100 && mem_addr == 10'h000, "R11 alias at user top", mem_addr, 0);
    cmd(6'b000100); frame_rd(mw(0), "R11 aliased read");
    for (int i = 256; i < 511; i++) cmd(6'b000110);
    chk(pc_o == 10'h1FF && mem_addr == 10'h0FF, "R11 last user address", mem_addr, 10'h0FF);
    // R9 crossing into configuration half
    cmd(6'b000110);
    chk(pc_o == 10'h200 && mem_addr == 10'h200, "R9 user to config", pc_o, 10'h200);
    // R10 wrap inside configuration half
    for (int i = 0; i < 511; i++) cmd(6'b000110);
    chk(pc_o == 10'h3FF, "R10 config top", pc_o, 10'h3FF);
    cmd(6'b000110);
    chk(pc_o == 10'h200, "R10 config wrap", pc_o, 10'h200);

    // R1 reset returns to 0
    do_reset();
    chk(pc_o == 0 && mem_addr == 0, "R1 reset clears counter", pc_o, 0);

    // R8 load configuration discards data
    n0 = nstrobe;
    cmd(6'b000000); frame_in(14'h3FFF);
    repeat (4) @(negedge clk);
    chk(pc_o == 10'h200 && nstrobe == n0, "R8 load config", pc_o, 10'h200);
    cmd(6'b000100); frame_rd(mw(10'h200), "R8 read config base");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 expected strobes seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule